// File: doc/BRIEF.md
# Command-Driven I2C Byte Master

This block is an I2C bus master that a host drives one byte-level step at a time. The host loads a transmit byte and then writes a command word. Bits in that word request a start condition, a byte write, a byte read, a stop condition, and the acknowledge value to return after a read. One word may combine several of these steps, and the engine runs them in the order START, then the data byte, then STOP. When the whole word is done, the engine sets an interrupt flag. The bus lines are open-drain: the block pulls SCL or SDA low through output enables and reads the real line levels back through two-stage synchronizers.

A prescaler counts `div+1` clock cycles per tick, and every bus step takes five ticks. Each data bit therefore lasts `5*(div+1)` cycles. The engine has four states:

- `E_IDLE` waits for a command.
- `E_START` releases both lines, pulls SDA low while SCL is high, then pulls SCL low.
- `E_BIT` shifts nine bits, which are eight data bits followed by the acknowledge bit.
- `E_STOP` pulls SDA low while SCL is low, releases SCL, then releases SDA.

The transitions are:

- A command leaves `E_IDLE` for its first requested step.
- `E_START` ends into `E_BIT` when a data byte is requested, otherwise into `E_STOP` or `E_IDLE`.
- `E_BIT` ends into `E_STOP` when a stop is requested, otherwise into `E_IDLE`.
- A lost arbitration takes `E_BIT` straight to `E_IDLE`.
- `E_STOP` ends in `E_IDLE`.

Top module: `i2c_byte_master`

## Requirements
- R1: Registers sit at byte offsets 0x00 control/status, 0x04 divider (16 bits), 0x08 command, 0x0C line status, 0x10 received byte, 0x14 transmit byte. After reset, control/status reads 0, `irq` is low and neither line is driven. Line status bit 4 is the sampled SCL and bit 3 the sampled SDA, so an idle-high bus reads both as 1.
- R2: In a data byte, consecutive SCL rising edges are exactly `5*(div+1)` clock cycles apart.
- R3: Command bits are start = bit 4, stop = bit 3, read = bit 2, write = bit 1, nack = bit 0. A START condition (SDA falling while SCL is high) comes first. A write then shifts the transmit byte out MSB first, so an address byte is the 7-bit address shifted left by one with bit 0 set to 1 for a read.
- R4: After a written byte, control/status bit 11 holds 1 if the slave left SDA high in the acknowledge bit, and 0 if it pulled SDA low.
- R5: A read shifts in eight bits MSB first and places them in the received-byte register. The master then drives ACK (low) in the ninth bit, or leaves SDA high (NACK) when the nack bit was set.
- R6: Control/status bit 10 (busy) rises when a START begins and falls only when a STOP completes; a STOP is SDA rising while SCL is high.
- R7: Control/status bit 2 sets when a command word completes and clears when 1 is written to it. `irq` is high only while this flag is set and control/status bits 1:0 are non-zero.
- R8: If the master leaves SDA high but samples it low, it stops driving both lines and sets control/status bit 9 and the flag.
- R9: A command written while an earlier command is still running is ignored.
- R10: Within a data byte, SDA changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| irq | output | 1 | Interrupt request |

## Verification
Errors in the phase counter or the state register show on the bus lines within one SCL period, as a spurious START or STOP or a wrong bit spacing. A bus monitor in the bench counts START and STOP events and measures edge spacing on every clock. A bit counter that is off by one shows after a single byte: the received byte, the acknowledge bit seen by the slave, or the nack bit holds the wrong value. A busy or hold flag left in the wrong state shows as a missing or extra STOP, or as SCL left released, by the time the next command word finishes.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    typedef enum logic [1:0] {
        E_IDLE,
        E_START,
        E_BIT,
        E_STOP
    } eng_state_e;

    // field order equals command bit order 4..0
    typedef struct packed {
        logic start;
        logic stop;
        logic rd;
        logic wr;
        logic nack;
    } cmd_t;

    localparam int unsigned BYTE_BITS = 8;
    localparam int unsigned PHASES    = 5;

    // register word indices (byte offset / 4)
    localparam int unsigned IDX_CSR = 0;
    localparam int unsigned IDX_DIV = 1;
    localparam int unsigned IDX_CMD = 2;
    localparam int unsigned IDX_SWR = 3;
    localparam int unsigned IDX_RXD = 4;
    localparam int unsigned IDX_TXD = 5;

    // control/status bit positions
    localparam int unsigned CSR_FLAG = 2;
    localparam int unsigned CSR_ARB  = 9;
    localparam int unsigned CSR_BUSY = 10;
    localparam int unsigned CSR_NACK = 11;

endpackage

// File: rtl/i2cm_prescaler.sv
module i2cm_prescaler #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
    import i2cm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  cmd_t       cmd,
    input  logic [BYTE_BITS-1:0] tx_byte,
    input  logic       tick,
    input  logic       scl_s,
    input  logic       sda_s,
    output logic       active,
    output logic       scl_drv,
    output logic       sda_drv,
    output logic       busy,
    output logic       done,
    output logic       arb_hit,
    output logic       ack_seen,
    output logic       ack_bit,
    output logic       rx_strobe,
    output logic [BYTE_BITS-1:0] rx_byte,
    output eng_state_e st,
    output logic [2:0] phase,
    output cmd_t       pend
);

    localparam logic [2:0] PH_HIGH  = 3'd2;
    localparam logic [2:0] PH_SAMP  = 3'd3;
    localparam logic [2:0] PH_LAST  = 3'(PHASES - 1);
    localparam logic [3:0] LAST_BIT = 4'(BYTE_BITS);
    localparam logic [3:0] MSB_BIT  = 4'(BYTE_BITS - 1);

    eng_state_e           state_q, state_d;
    logic [2:0]           phase_q;
    logic [3:0]           bitn_q;
    logic [BYTE_BITS-1:0] shreg_q;
    cmd_t                 pend_q;
    logic                 hold_q;
    logic                 busy_q;

    logic adv, last_ph, smp, rd_mode, bit_out, lost;

    function automatic eng_state_e after_start(cmd_t c);
        if (c.rd || c.wr)  return E_BIT;
        else if (c.stop)   return E_STOP;
        else               return E_IDLE;
    endfunction

    function automatic eng_state_e first_op(cmd_t c);
        if (c.start) return E_START;
        else         return after_start(c);
    endfunction

    // step control and next state
    always_comb begin
        adv     = tick && !(phase_q == PH_HIGH && !scl_s);
        last_ph = adv && (phase_q == PH_LAST);
        smp     = adv && (phase_q == PH_SAMP) && (state_q == E_BIT);
        rd_mode = pend_q.rd && !pend_q.wr;
        if (bitn_q == LAST_BIT) bit_out = rd_mode ? pend_q.nack : 1'b1;
        else                    bit_out = rd_mode ? 1'b1 : shreg_q[BYTE_BITS-1];
        lost = smp && bit_out && !sda_s &&
               (rd_mode ? (bitn_q == LAST_BIT) : (bitn_q != LAST_BIT));
        state_d = state_q;
        unique case (state_q)
            E_IDLE:  if (go) state_d = first_op(cmd);
            E_START: if (last_ph) state_d = after_start(pend_q);
            E_BIT: begin
                if (lost) state_d = E_IDLE;
                else if (last_ph && bitn_q == LAST_BIT)
                    state_d = pend_q.stop ? E_STOP : E_IDLE;
            end
            E_STOP:  if (last_ph) state_d = E_IDLE;
            default: state_d = E_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= E_IDLE;
            phase_q <= '0;
            bitn_q  <= '0;
            shreg_q <= '0;
            pend_q  <= '0;
            hold_q  <= 1'b0;
            busy_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (go && state_q == E_IDLE) pend_q <= cmd;
            if (state_d != state_q) begin
                phase_q <= '0;
                bitn_q  <= '0;
                if (state_d == E_BIT) shreg_q <= tx_byte;
            end else if (adv) begin
                phase_q <= (phase_q == PH_LAST) ? 3'd0 : phase_q + 3'd1;
                if (state_q == E_BIT && phase_q == PH_LAST) begin
                    bitn_q <= bitn_q + 4'd1;
                    if (!rd_mode) shreg_q <= {shreg_q[BYTE_BITS-2:0], 1'b0};
                end
                if (smp && rd_mode && bitn_q != LAST_BIT)
                    shreg_q <= {shreg_q[BYTE_BITS-2:0], sda_s};
            end
            if (state_q == E_START && last_ph) hold_q <= 1'b1;
            if ((state_q == E_STOP && last_ph) || lost) hold_q <= 1'b0;
            if (state_d == E_START && state_q != E_START) busy_q <= 1'b1;
            else if (state_q == E_STOP && last_ph)        busy_q <= 1'b0;
        end
    end

    // line drives per state and phase
    always_comb begin
        unique case (state_q)
            E_IDLE: begin
                scl_drv = hold_q;
                sda_drv = 1'b0;
            end
            E_START: begin
                scl_drv = (phase_q == 3'd0) ? hold_q : (phase_q == PH_LAST);
                sda_drv = (phase_q >= PH_SAMP);
            end
            E_BIT: begin
                scl_drv = (phase_q < PH_HIGH) || (phase_q == PH_LAST);
                sda_drv = !bit_out;
            end
            E_STOP: begin
                scl_drv = (phase_q < PH_HIGH);
                sda_drv = (phase_q != 3'd0) && (phase_q != PH_LAST);
            end
            default: begin
                scl_drv = 1'b0;
                sda_drv = 1'b0;
            end
        endcase
    end

    assign active    = (state_q != E_IDLE);
    assign done      = (state_q != E_IDLE) && (state_d == E_IDLE);
    assign arb_hit   = lost;
    assign ack_seen  = smp && !rd_mode && (bitn_q == LAST_BIT);
    assign ack_bit   = sda_s;
    assign rx_strobe = smp && rd_mode && (bitn_q == MSB_BIT);
    assign rx_byte   = {shreg_q[BYTE_BITS-2:0], sda_s};
    assign busy      = busy_q;
    assign st        = state_q;
    assign phase     = phase_q;
    assign pend      = pend_q;

endmodule

// File: rtl/i2cm_regs.sv
module i2cm_regs
    import i2cm_pkg::*;
#(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              active,
    input  logic              done,
    input  logic              arb_hit,
    input  logic              ack_seen,
    input  logic              ack_bit,
    input  logic              rx_strobe,
    input  logic [BYTE_BITS-1:0] rx_byte,
    input  logic              busy,
    input  logic              scl_s,
    input  logic              sda_s,
    output logic              go,
    output cmd_t              cmd,
    output logic [BYTE_BITS-1:0] tx_byte,
    output logic [DIV_W-1:0]  div,
    output logic              flag,
    output logic              irq
);

    localparam int unsigned IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]     idx;
    logic [1:0]           ie_q;
    logic                 flag_q, arb_q, nack_q;
    logic [DIV_W-1:0]     div_q;
    logic [BYTE_BITS-1:0] tx_q, rx_q;
    logic                 csr_wr;
    logic                 unused_bits;

    assign idx         = bus_addr[ADDR_W-1:2];
    assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-1:DIV_W]};
    assign csr_wr      = bus_wr && (idx == IDX_W'(IDX_CSR));
    assign cmd         = cmd_t'(bus_wdata[4:0]);
    assign go          = bus_wr && (idx == IDX_W'(IDX_CMD)) && !active && (|bus_wdata[4:1]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_q   <= '0;
            flag_q <= 1'b0;
            arb_q  <= 1'b0;
            nack_q <= 1'b0;
            div_q  <= '0;
            tx_q   <= '0;
            rx_q   <= '0;
        end else begin
            if (csr_wr) ie_q <= bus_wdata[1:0];
            if (done)                               flag_q <= 1'b1;
            else if (csr_wr && bus_wdata[CSR_FLAG]) flag_q <= 1'b0;
            if (arb_hit) arb_q <= 1'b1;
            else if (go) arb_q <= 1'b0;
            if (ack_seen)  nack_q <= ack_bit;
            if (rx_strobe) rx_q   <= rx_byte;
            if (bus_wr && idx == IDX_W'(IDX_DIV)) div_q <= bus_wdata[DIV_W-1:0];
            if (bus_wr && idx == IDX_W'(IDX_TXD)) tx_q  <= bus_wdata[BYTE_BITS-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (idx)
            IDX_W'(IDX_CSR): begin
                bus_rdata[1:0]      = ie_q;
                bus_rdata[CSR_FLAG] = flag_q;
                bus_rdata[CSR_ARB]  = arb_q;
                bus_rdata[CSR_BUSY] = busy;
                bus_rdata[CSR_NACK] = nack_q;
            end
            IDX_W'(IDX_DIV): bus_rdata[DIV_W-1:0]     = div_q;
            IDX_W'(IDX_SWR): bus_rdata[4:3]           = {scl_s, sda_s};
            IDX_W'(IDX_RXD): bus_rdata[BYTE_BITS-1:0] = rx_q;
            IDX_W'(IDX_TXD): bus_rdata[BYTE_BITS-1:0] = tx_q;
            default:         bus_rdata                = '0;
        endcase
    end

    assign tx_byte = tx_q;
    assign div     = div_q;
    assign flag    = flag_q;
    assign irq     = flag_q && (|ie_q);

endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
    import i2cm_pkg::*;
#(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DIV_W  = 16,
    parameter int unsigned SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              irq
);

    logic [SYNC_N-1:0] scl_sync, sda_sync;
    logic scl_s, sda_s;
    logic go, tick, active, busy, done, arb_hit, ack_seen, ack_bit, rx_strobe, flag;
    logic [BYTE_BITS-1:0] tx_byte, rx_byte;
    logic [DIV_W-1:0] div;
    cmd_t cmd, pend;
    eng_state_e st;
    logic [2:0] phase;

    generate
        if (SYNC_N == 1) begin : g_sync1
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_sync <= '1;
                    sda_sync <= '1;
                end else begin
                    scl_sync <= scl_in;
                    sda_sync <= sda_in;
                end
            end
        end else begin : g_syncn
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_sync <= '1;
                    sda_sync <= '1;
                end else begin
                    scl_sync <= {scl_sync[SYNC_N-2:0], scl_in};
                    sda_sync <= {sda_sync[SYNC_N-2:0], sda_in};
                end
            end
        end
    endgenerate

    assign scl_s = scl_sync[SYNC_N-1];
    assign sda_s = sda_sync[SYNC_N-1];

    i2cm_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .active(active), .done(done),
        .arb_hit(arb_hit), .ack_seen(ack_seen), .ack_bit(ack_bit),
        .rx_strobe(rx_strobe), .rx_byte(rx_byte), .busy(busy), .scl_s(scl_s),
        .sda_s(sda_s), .go(go), .cmd(cmd), .tx_byte(tx_byte), .div(div),
        .flag(flag), .irq(irq)
    );

    i2cm_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(active), .div(div), .tick(tick)
    );

    i2cm_engine u_eng (
        .clk(clk), .rst_n(rst_n), .go(go), .cmd(cmd), .tx_byte(tx_byte),
        .tick(tick), .scl_s(scl_s), .sda_s(sda_s), .active(active),
        .scl_drv(scl_oe), .sda_drv(sda_oe), .busy(busy), .done(done),
        .arb_hit(arb_hit), .ack_seen(ack_seen), .ack_bit(ack_bit),
        .rx_strobe(rx_strobe), .rx_byte(rx_byte), .st(st), .phase(phase),
        .pend(pend)
    );

endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker
    import i2cm_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic [4:0] bus_addr,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic       irq,
    input logic       active,
    input logic       done,
    input logic       flag,
    input logic       arb_hit,
    input logic       busy,
    input eng_state_e st,
    input logic [2:0] phase,
    input cmd_t       pend
);

    AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        phase < 3'(PHASES)); // R2

    AST_SDA_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (st == E_BIT && $past(st) == E_BIT && !scl_oe && !$past(scl_oe)) |-> $stable(sda_oe)); // R10

    AST_CMD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (active && bus_wr && bus_addr[4:2] == 3'(IDX_CMD)) |=> $stable(pend)); // R9

    AST_ARB_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        arb_hit |=> (!scl_oe && !sda_oe)); // R8

    AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> flag); // R7

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !flag |-> !irq); // R7

    AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(st) == E_STOP)); // R6

endmodule

bind i2c_byte_master i2cm_checker u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq), .active(active),
    .done(done), .flag(flag), .arb_hit(arb_hit), .busy(busy),
    .st(st), .phase(phase), .pend(pend)
);

// File: tb/i2c_byte_master_test.sv
module i2c_byte_master_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        scl_in, sda_in, scl_oe, sda_oe, irq;

    int n_chk = 0;
    int n_fail = 0;

    // bus and slave model state
    logic sl_low = 1'b0, rival = 1'b0, sl_rx = 1'b1, sl_ack_en = 1'b0, sl_mack = 1'b0;
    logic [7:0] sl_txb = '0, sl_shift = '0;
    int   sl_cnt = 0;
    int   n_start = 0, n_stop = 0;
    int   cyc = 0, last_rise = -1, gap = 0;
    logic p_scl = 1'b1, p_sda = 1'b1;
    logic ie_model = 1'b0;

    wire scl_line = !scl_oe;
    wire sda_line = !(sda_oe || sl_low || rival);
    assign scl_in = scl_line;
    assign sda_in = sda_line;

    always #4 clk = !clk;

    i2c_byte_master uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .scl_in(scl_in),
        .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // per-clock bus monitor, slave model and interrupt reference
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (p_scl && scl_line && p_sda && !sda_line) begin
                n_start++;
                sl_cnt = -1;
            end
            if (p_scl && scl_line && !p_sda && sda_line) n_stop++;
            if (!p_scl && scl_line) begin
                if (last_rise >= 0) gap = cyc - last_rise;
                last_rise = cyc;
                if (sl_rx && sl_cnt >= 0 && sl_cnt < 8) sl_shift = {sl_shift[6:0], sda_line};
                if (!sl_rx && sl_cnt == 8) sl_mack = sda_line;
            end
            if (p_scl && !scl_line) begin
                sl_cnt++;
                if (sl_rx) sl_low = (sl_cnt == 8) && sl_ack_en;
                else       sl_low = (sl_cnt >= 0 && sl_cnt < 8) ? !sl_txb[7 - sl_cnt] : 1'b0;
            end
            if (!ie_model && irq) begin
                n_chk++;
                n_fail++;
                $display("FAIL R7: actual irq %b expected 0 with enable clear", irq);
            end
        end
        p_scl = scl_line;
        p_sda = sda_line;
    end

    task automatic reg_wr(input int idx, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_addr = 5'(idx * 4);
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic reg_rd(input int idx, output logic [31:0] v);
        @(negedge clk);
        bus_addr = 5'(idx * 4);
        #1 v = bus_rdata;
    endtask

    task automatic wait_flag(input string req);
        logic [31:0] v;
        int n = 0;
        do begin
            reg_rd(0, v);
            n++;
        end while (!v[2] && n < 20000);
        check(req, 32'(v[2]), 32'd1);
    endtask

    task automatic arm_rx(input logic ack);
        @(negedge clk);
        sl_rx = 1'b1; sl_cnt = 0; sl_low = 1'b0; sl_ack_en = ack;
    endtask

    task automatic arm_tx(input logic [7:0] b);
        @(negedge clk);
        sl_rx = 1'b0; sl_cnt = 0; sl_txb = b; sl_low = !b[7];
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        // R1 reset state
        reg_rd(0, v);   check("R1 csr reset", v, 32'h0);
        check("R1 irq reset", 32'(irq), 32'd0);
        check("R1 lines undriven", 32'({scl_oe, sda_oe}), 32'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        reg_rd(3, v);   check("R1 idle lines", 32'(v[4:3]), 32'd3);

        reg_wr(1, 32'd3);
        reg_rd(1, v);   check("R1 divider readback", v, 32'd3);
        ie_model = 1'b1;
        reg_wr(0, 32'h1);

        // R3: START plus address write, address 0x50 for write -> 0xA0
        reg_wr(5, 32'hA0);
        arm_rx(1'b1);
        reg_wr(2, 32'h12);
        repeat (30) @(negedge clk);
        reg_wr(2, 32'h08);              // R9 stop while running must be ignored
        wait_flag("R7 flag after start+write");
        check("R3 address byte", 32'(sl_shift), 32'hA0);
        check("R3 one start", 32'(n_start), 32'd1);
        check("R2 scl period", 32'(gap), 32'd20);
        reg_rd(0, v);
        check("R4 ack recorded", 32'(v[11]), 32'd0);
        check("R6 busy after start", 32'(v[10]), 32'd1);
        check("R9 no stop emitted", 32'(n_stop), 32'd0);
        check("R7 irq high", 32'(irq), 32'd1);
        reg_wr(0, 32'h5);
        reg_rd(0, v);   check("R7 flag cleared", 32'(v[2]), 32'd0);
        check("R7 irq low", 32'(irq), 32'd0);

        // R4 data byte refused by slave
        reg_wr(5, 32'h3C);
        arm_rx(1'b0);
        reg_wr(2, 32'h02);
        wait_flag("R7 flag after write");
        check("R3 data byte", 32'(sl_shift), 32'h3C);
        reg_rd(0, v);   check("R4 nack recorded", 32'(v[11]), 32'd1);
        reg_wr(0, 32'h5);

        // repeated start, read address 0x50 -> 0xA1
        reg_wr(5, 32'hA1);
        arm_rx(1'b1);
        reg_wr(2, 32'h12);
        wait_flag("R7 flag after restart");
        check("R3 restart count", 32'(n_start), 32'd2);
        check("R3 read address", 32'(sl_shift), 32'hA1);
        reg_rd(0, v);   check("R4 ack after nack", 32'(v[11]), 32'd0);
        reg_wr(0, 32'h5);

        // R5 read with ACK
        arm_tx(8'hA5);
        reg_wr(2, 32'h04);
        wait_flag("R7 flag after read");
        reg_rd(4, v);   check("R5 rx byte", v, 32'hA5);
        check("R5 master ack", 32'(sl_mack), 32'd0);
        reg_wr(0, 32'h5);

        // R5/R6 read with NACK then STOP
        arm_tx(8'h5A);
        reg_wr(2, 32'h0D);
        wait_flag("R7 flag after read+stop");
        reg_rd(4, v);   check("R5 last rx byte", v, 32'h5A);
        check("R5 master nack", 32'(sl_mack), 32'd1);
        check("R6 stop count", 32'(n_stop), 32'd1);
        reg_rd(0, v);   check("R6 busy cleared", 32'(v[10]), 32'd0);
        reg_rd(3, v);   check("R1 idle after stop", 32'(v[4:3]), 32'd3);

        // R7 enable clear, flag set
        reg_wr(0, 32'h4);
        ie_model = 1'b0;
        arm_rx(1'b0);
        reg_wr(2, 32'h10);
        wait_flag("R7 flag after start only");
        check("R7 irq gated", 32'(irq), 32'd0);
        check("R3 third start", 32'(n_start), 32'd3);
        reg_wr(0, 32'h4);

        // R8 arbitration: another master holds SDA low
        rival = 1'b1;
        reg_wr(5, 32'hFF);
        reg_wr(2, 32'h02);
        wait_flag("R8 flag on loss");
        reg_rd(0, v);
        check("R8 arb bit", 32'(v[9]), 32'd1);
        check("R8 lines released", 32'({scl_oe, sda_oe}), 32'd0);
        rival = 1'b0;
        repeat (4) @(negedge clk);
        check("R8 rival stop seen", 32'(n_stop), 32'd2);
        reg_wr(0, 32'h4);
        reg_wr(2, 32'h08);
        wait_flag("R6 flag after stop");
        reg_rd(0, v);
        check("R6 busy after stop", 32'(v[10]), 32'd0);
        check("R8 arb cleared by command", 32'(v[9]), 32'd0);
        check("R6 final stop count", 32'(n_stop), 32'd3);
        check("R10 start count steady", 32'(n_start), 32'd3);
        finish_up();
    end

endmodule